// File: doc/BRIEF.md
# Segmented Subroutine Call Sequencer

This block carries out the multi-cycle subroutine-call operation of a small 8-bit controller whose program counter is 15 bits wide. When a start strobe arrives with the two fetched bytes of a call instruction and the address of its first byte, the block computes the return address, which is that address plus two. It pushes the return address onto a downward-growing stack in data memory through a byte-wide write port, one byte per clock. It then hands the controller a new program counter and a new stack pointer value, each with a load strobe.

The call instruction holds only 12 target bits: a nibble in the first byte and a full second byte. The three top bits of the new program counter come from the 4K segment of the return address, not from the segment of the call itself. A call placed in the last two bytes of a segment therefore lands in the next segment. A start whose opcode does not carry the call pattern is refused with a one-cycle flag. A start that arrives while a call is still in progress is ignored.

Top module: `segcall_top`

## Requirements
- R1: After reset, mem_we_o, pc_load_o, sp_load_o, done_o, illegal_o and busy_o are all 0.
- R2: The return address is (pc_i + 2) modulo 2^15. The loaded target has bits 14:12 equal to return-address bits 14:12, bits 11:8 equal to opc_i[3:0] and bits 7:0 equal to opr_i.
- R3: A call whose first byte sits at offset 0xFFE or 0xFFF of a 4K segment jumps into the following segment. A call at 0x7FFE wraps its return address to 0x0000 and jumps into segment 0.
- R4: In the first cycle after an accepted start, mem_we_o=1, mem_addr_o equals the stack pointer sampled at start, and mem_wdata_o equals return-address bits 7:0.
- R5: In the second cycle, mem_we_o=1, mem_addr_o equals (stack pointer - 1) modulo 256, and mem_wdata_o equals {1'b0, return-address bits 14:8}. mem_we_o is 0 in every other cycle.
- R6: In the fifth cycle after an accepted start, done_o, pc_load_o and sp_load_o are 1 for exactly one cycle. pc_o then equals the target and sp_o equals (stack pointer - 2) modulo 256.
- R7: A start strobe raised while busy_o is 1 is ignored. The running call completes with its own values, and no further write or load follows.
- R8: A start whose opc_i[7:4] is not 4'h3 is rejected. illegal_o is 1 for exactly the next cycle, no write or load strobe is raised, and busy_o stays 0.
- R9: busy_o is 1 in cycles 1 through 5 after an accepted start and 0 in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to execute a call, sampled when idle |
| opc_i | input | 8 | First instruction byte (pattern 0x3N) |
| opr_i | input | 8 | Second instruction byte, target bits 7:0 |
| pc_i | input | 15 | Address of the call's first byte |
| sp_i | input | 8 | Current stack pointer |
| mem_we_o | output | 1 | Data-memory write enable |
| mem_addr_o | output | 8 | Data-memory write address |
| mem_wdata_o | output | 8 | Data-memory write byte |
| pc_load_o | output | 1 | Load strobe for the new program counter |
| pc_o | output | 15 | New program counter |
| sp_load_o | output | 1 | Load strobe for the new stack pointer |
| sp_o | output | 8 | New stack pointer |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | One-cycle rejected-opcode flag |
| busy_o | output | 1 | Call sequence in progress |

## Verification
The bench builds the block with its default parameters: a 15-bit program counter, an 8-bit stack pointer, 12-bit in-instruction target and a five-cycle latency. With these values the segment carry at 0x0FFE and 0x0FFF, the wrap of the whole program space at 0x7FFE and the stack-pointer wrap through 0x00 can each be reached with one directed call. With the short latency, a start injected in the middle of a running call falls in a cycle where it could visibly restart the sequence.

// File: rtl/segcall_pkg.sv
// segcall_pkg: shared types for the segmented call sequencer.
// Assumes: one phase value per cycle of the call sequence.
package segcall_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_LO   = 3'd1,
        PH_HI   = 3'd2,
        PH_WAIT = 3'd3,
        PH_DONE = 3'd4
    } seq_phase_t;

    localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/segcall_target.sv
// segcall_target: combinational return-address and call-target computation.
// The segment bits of the target are taken from the return address.
// Assumes: OFF_W > BYTE_W and OFF_W - BYTE_W <= 4 (nibble of opcode).
module segcall_target #(
    parameter int unsigned PC_W  = 15,
    parameter int unsigned OFF_W = 12
) (
    input  logic [PC_W-1:0] pc_i,
    input  logic [7:0]      opc_i,
    input  logic [7:0]      opr_i,
    output logic [PC_W-1:0] ret_o,
    output logic [PC_W-1:0] tgt_o
);
    localparam int unsigned NIB_W = OFF_W - 8;

    // Purpose: form return address and segment-relative target.
    always_comb begin
        ret_o = pc_i + PC_W'(2);
        tgt_o = {ret_o[PC_W-1:OFF_W], opc_i[NIB_W-1:0], opr_i};
    end
endmodule

// File: rtl/segcall_ctrl.sv
// segcall_ctrl: cycle counter that steps a call through its phases.
// Accepts a start only when idle. Flags bad opcodes for one cycle.
// Assumes: LAT >= 3 so both pushes precede completion.
module segcall_ctrl
    import segcall_pkg::*;
#(
    parameter int unsigned LAT = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       legal_i,
    output logic       accept_o,
    output seq_phase_t phase_o,
    output logic       illegal_o
);
    localparam int unsigned CNT_W = $clog2(LAT + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             illegal_q;

    // Purpose: a start is taken only in the idle phase.
    always_comb accept_o = start_i && (cnt_q == '0);

    // Purpose: advance the counter through the sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (accept_o && legal_i) begin
            cnt_q <= CNT_W'(1);
        end else if (cnt_q == CNT_W'(LAT)) begin
            cnt_q <= '0;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // Purpose: one-cycle flag for a refused opcode.
    always_ff @(posedge clk) begin
        if (!rst_n) illegal_q <= 1'b0;
        else        illegal_q <= accept_o && !legal_i;
    end

    // Purpose: decode counter into a phase.
    always_comb begin
        if (cnt_q == '0)                phase_o = PH_IDLE;
        else if (cnt_q == CNT_W'(1))    phase_o = PH_LO;
        else if (cnt_q == CNT_W'(2))    phase_o = PH_HI;
        else if (cnt_q == CNT_W'(LAT))  phase_o = PH_DONE;
        else                            phase_o = PH_WAIT;
    end

    assign illegal_o = illegal_q;

    // R6: completion lasts one cycle and returns to idle
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_DONE) |=> (phase_o == PH_IDLE));
    // R7: a running sequence is never restarted
    a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o != PH_IDLE) |=> (phase_o != PH_LO));
    // R8: illegal flag is a single-cycle pulse
    a_r8_illegal_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_q |=> !illegal_q);
endmodule

// File: rtl/segcall_push.sv
// segcall_push: drives the byte-wide data-memory write port for both pushes.
// Low return byte at SP, then upper byte (bit 7 cleared) at SP-1.
// Assumes: PC_W - 8 < 8 so the upper byte fits with zero padding.
module segcall_push
    import segcall_pkg::*;
#(
    parameter int unsigned PC_W = 15,
    parameter int unsigned SP_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  seq_phase_t      phase_i,
    input  logic [PC_W-1:0] ret_i,
    input  logic [SP_W-1:0] sp_i,
    output logic            we_o,
    output logic [SP_W-1:0] addr_o,
    output logic [7:0]      wdata_o
);
    localparam int unsigned HI_W  = PC_W - 8;
    localparam int unsigned PAD_W = 8 - HI_W;

    // Purpose: select write address and byte per phase.
    always_comb begin
        we_o    = 1'b0;
        addr_o  = sp_i;
        wdata_o = ret_i[7:0];
        if (phase_i == PH_LO) begin
            we_o = 1'b1;
        end else if (phase_i == PH_HI) begin
            we_o    = 1'b1;
            addr_o  = sp_i - SP_W'(1);
            wdata_o = {{PAD_W{1'b0}}, ret_i[PC_W-1:8]};
        end
    end

    // R5: back-to-back writes go to descending addresses
    a_r5_descend: assert property (@(posedge clk) disable iff (!rst_n)
        (we_o && $past(we_o)) |-> (addr_o == $past(addr_o) - SP_W'(1)));
    // R5: upper byte never has bit 7 set
    a_r5_hi_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (we_o && $past(we_o)) |-> !wdata_o[7]);
endmodule

// File: rtl/segcall_top.sv
// segcall_top: segmented subroutine-call sequencer.
// Captures the call operands on an accepted start, pushes the return
// address over two cycles and loads the new PC and SP at the end.
// Assumes: caller holds its PC/SP registers until the load strobes.
module segcall_top
    import segcall_pkg::*;
#(
    parameter int unsigned PC_W     = 15,
    parameter int unsigned SP_W     = 8,
    parameter int unsigned OFF_W    = 12,
    parameter int unsigned LAT      = 5,
    parameter logic [3:0]  CALL_NIB = 4'h3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [7:0]      opc_i,
    input  logic [7:0]      opr_i,
    input  logic [PC_W-1:0] pc_i,
    input  logic [SP_W-1:0] sp_i,
    output logic            mem_we_o,
    output logic [SP_W-1:0] mem_addr_o,
    output logic [7:0]      mem_wdata_o,
    output logic            pc_load_o,
    output logic [PC_W-1:0] pc_o,
    output logic            sp_load_o,
    output logic [SP_W-1:0] sp_o,
    output logic            done_o,
    output logic            illegal_o,
    output logic            busy_o
);
    seq_phase_t      phase;
    logic            accept;
    logic            legal;
    logic [PC_W-1:0] ret_c, tgt_c;
    logic [PC_W-1:0] ret_q, tgt_q;
    logic [SP_W-1:0] sp_q;

    // Purpose: recognise the call opcode pattern.
    always_comb legal = (opc_i[7:4] == CALL_NIB);

    segcall_target #(.PC_W(PC_W), .OFF_W(OFF_W)) u_tgt (
        .pc_i (pc_i),
        .opc_i(opc_i),
        .opr_i(opr_i),
        .ret_o(ret_c),
        .tgt_o(tgt_c)
    );

    segcall_ctrl #(.LAT(LAT)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .legal_i  (legal),
        .accept_o (accept),
        .phase_o  (phase),
        .illegal_o(illegal_o)
    );

    // Purpose: hold operands for the duration of the call.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_q <= '0;
            tgt_q <= '0;
            sp_q  <= '0;
        end else if (accept && legal) begin
            ret_q <= ret_c;
            tgt_q <= tgt_c;
            sp_q  <= sp_i;
        end
    end

    segcall_push #(.PC_W(PC_W), .SP_W(SP_W)) u_push (
        .clk    (clk),
        .rst_n  (rst_n),
        .phase_i(phase),
        .ret_i  (ret_q),
        .sp_i   (sp_q),
        .we_o   (mem_we_o),
        .addr_o (mem_addr_o),
        .wdata_o(mem_wdata_o)
    );

    // Purpose: completion outputs.
    always_comb begin
        done_o    = (phase == PH_DONE);
        pc_load_o = done_o;
        sp_load_o = done_o;
        pc_o      = tgt_q;
        sp_o      = sp_q - SP_W'(2);
        busy_o    = (phase != PH_IDLE);
    end

    // R6: loads never coincide with a memory write
    a_r6_load_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load_o |-> (sp_load_o && !mem_we_o));
    // R8: a refused opcode produces no side effect
    a_r8_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (!mem_we_o && !pc_load_o && !busy_o));
    // R5: writes happen only inside a busy sequence
    a_r5_we_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> busy_o);
    // R2: the target stays stable while the call runs
    a_r2_tgt_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(pc_o));
endmodule

// File: tb/sim_segcall_top.sv
// sim_segcall_top: directed bench for the segmented call sequencer.
module sim_segcall_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  opc_i = '0;
    logic [7:0]  opr_i = '0;
    logic [14:0] pc_i = '0;
    logic [7:0]  sp_i = '0;
    logic        mem_we_o;
    logic [7:0]  mem_addr_o;
    logic [7:0]  mem_wdata_o;
    logic        pc_load_o;
    logic [14:0] pc_o;
    logic        sp_load_o;
    logic [7:0]  sp_o;
    logic        done_o;
    logic        illegal_o;
    logic        busy_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    segcall_top u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .opc_i(opc_i),
        .opr_i(opr_i), .pc_i(pc_i), .sp_i(sp_i), .mem_we_o(mem_we_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
        .pc_load_o(pc_load_o), .pc_o(pc_o), .sp_load_o(sp_load_o),
        .sp_o(sp_o), .done_o(done_o), .illegal_o(illegal_o), .busy_o(busy_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({mem_we_o, pc_load_o, sp_load_o, done_o, illegal_o, busy_o} == 6'b0,
            "R1 reset outputs", int'({mem_we_o, pc_load_o, sp_load_o, done_o, illegal_o, busy_o}), 0);
    endtask

    // Run one call; optional extra start during cycle 3 (R7).
    task automatic run_call(input logic [7:0] opc, input logic [7:0] opr,
                            input logic [14:0] pc, input logic [7:0] sp,
                            input bit mid_start, input string tag);
        logic [14:0] ret, tgt;
        ret = pc + 15'd2;
        tgt = {ret[14:12], opc[3:0], opr};
        start_i = 1'b1; opc_i = opc; opr_i = opr; pc_i = pc; sp_i = sp;
        @(negedge clk);
        start_i = 1'b0;
        for (int c = 1; c <= 7; c++) begin
            if (c == 1) begin
                chk(mem_we_o && mem_addr_o == sp, {tag, " R4 lo addr"}, int'(mem_addr_o), int'(sp));
                chk(mem_wdata_o == ret[7:0], {tag, " R4 lo data"}, int'(mem_wdata_o), int'(ret[7:0]));
            end else if (c == 2) begin
                chk(mem_we_o && mem_addr_o == sp - 8'd1, {tag, " R5 hi addr"}, int'(mem_addr_o), int'(sp - 8'd1));
                chk(mem_wdata_o == {1'b0, ret[14:8]}, {tag, " R5 hi data"}, int'(mem_wdata_o), int'({1'b0, ret[14:8]}));
            end else if (c == 5) begin
                chk(done_o && pc_load_o && sp_load_o, {tag, " R6 strobes"},
                    int'({done_o, pc_load_o, sp_load_o}), 7);
                chk(pc_o == tgt, {tag, " R2 target"}, int'(pc_o), int'(tgt));
                chk(sp_o == sp - 8'd2, {tag, " R6 new sp"}, int'(sp_o), int'(sp - 8'd2));
                chk(!mem_we_o, {tag, " R5 no write"}, int'(mem_we_o), 0);
            end else if (c >= 6) begin
                chk(!busy_o && !mem_we_o && !done_o, {tag, " R9/R7 idle after"},
                    int'({busy_o, mem_we_o, done_o}), 0);
            end else begin
                chk(!mem_we_o && !done_o, {tag, " R5 quiet wait"}, int'({mem_we_o, done_o}), 0);
            end
            if (c >= 1 && c <= 5)
                chk(busy_o, {tag, " R9 busy"}, int'(busy_o), 1);
            if (mid_start && c == 3) begin
                start_i = 1'b1; opc_i = 8'h3A; opr_i = 8'h55; pc_i = 15'h0100; sp_i = 8'h40;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
    endtask

    task automatic t_plain();      run_call(8'h35, 8'hA7, 15'h2340, 8'h80, 0, "plain");   endtask
    task automatic t_seg_cross();  run_call(8'h31, 8'h22, 15'h0FFE, 8'h70, 0, "R3 0FFE"); endtask
    task automatic t_seg_cross2(); run_call(8'h3F, 8'hFF, 15'h3FFF, 8'h60, 0, "R3 3FFF"); endtask
    task automatic t_top_wrap();   run_call(8'h30, 8'h10, 15'h7FFE, 8'h50, 0, "R3 7FFE"); endtask
    task automatic t_sp_wrap();    run_call(8'h3C, 8'h01, 15'h5123, 8'h01, 0, "R5 sp01"); endtask
    task automatic t_sp_zero();    run_call(8'h32, 8'h9E, 15'h6FF0, 8'h00, 0, "R6 sp00"); endtask
    task automatic t_busy();       run_call(8'h34, 8'h44, 15'h1200, 8'hC0, 1, "R7 busy"); endtask

    task automatic t_illegal();
        start_i = 1'b1; opc_i = 8'h4A; opr_i = 8'h12; pc_i = 15'h0200; sp_i = 8'h90;
        @(negedge clk);
        start_i = 1'b0;
        chk(illegal_o, "R8 flag", int'(illegal_o), 1);
        chk(!mem_we_o && !pc_load_o && !sp_load_o && !busy_o, "R8 no effect",
            int'({mem_we_o, pc_load_o, sp_load_o, busy_o}), 0);
        @(negedge clk);
        chk(!illegal_o && !busy_o, "R8 one cycle", int'({illegal_o, busy_o}), 0);
        repeat (5) begin
            @(negedge clk);
            chk(!mem_we_o && !pc_load_o, "R8 stays idle", int'({mem_we_o, pc_load_o}), 0);
        end
    endtask

    initial begin
        t_reset();
        t_plain();
        t_seg_cross();
        t_seg_cross2();
        t_top_wrap();
        t_sp_wrap();
        t_sp_zero();
        t_busy();
        t_illegal();
        t_plain();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule